// File: doc/BRIEF.md
# Panel Power and Init Sequencer

This block brings a display panel up and takes it down again by walking a small constant script. Each script entry is one of four operations: a register write handed to an external serial register writer, a delay measured in milliseconds, a delay measured in whole video frames, or an end marker. Frame delays are timed from rising edges of a vertical-sync input. Each frame request is padded so that every requested frame has passed in full, with one more edge added as a safety margin.

Besides the script, the block drives the panel reset line (active low) and the panel power enable. A start-up request from the inactive state does the following in order: it pulses reset, enables power, lets the supply settle and then runs the start-up part of the script. A shut-down request from the active state runs the shut-down part of the script, removes power and waits for the supply to decay. A one-cycle `done` pulse marks the end of either sequence. The `active` flag then shows the resulting power state.

Top module: `panel_seq`

## Requirements
- R1: After reset, `busy`, `done`, `active`, `powerEn` and `wrValid` are low and `panelRstN` is high.
- R2: A start-up from the inactive state drives `panelRstN` low for RST_HOLD_MS milliseconds. It then drives it high for RST_HOLD_MS milliseconds, and only then raises `powerEn`. The first script write is accepted PWR_HOLD_MS milliseconds after `powerEn` rises. `wrValid` is never high while `powerEn` is low or `panelRstN` is low.
- R3: A write is presented on `wrValid` with `wrAddr` (8-bit register number) and `wrData` (16-bit value). Address and data stay stable until a cycle with `wrReady` high accepts the write. Writes occur in script order. Start-up order: 07=0000, wait 10 ms, 12=1618, 11=2227, 13=61D1, 10=550C, wait 5 frames, 12=0C58, 01=231D, 02=0300, 03=D040, 07=0001, wait 1 frame, 07=0101, wait 2 frames, 76=2213, 1C=6650, 0B=33E1, 76=0000, 07=0103. Shut-down order: 0B=30E1, 07=0102, wait 2 frames, 07=0000, 12=0000, 10=0100 (all values hex).
- R4: A millisecond wait of N lasts N×CLK_PER_MS cycles, plus a fixed overhead of a few cycles.
- R5: A frame wait of N ends after exactly N+FRAME_PAD rising edges of `vsyncIn` (FRAME_PAD defaults to 2). Counting starts in the cycle after the wait begins.
- R6: At the end of start-up, `done` is high for exactly one cycle. In that cycle `busy` is low and `active` is high.
- R7: At the end of the shut-down script, `powerEn` falls within three cycles of the last write being accepted. `done` follows PWR_HOLD_MS milliseconds later with `active` low, and `panelRstN` stays high throughout.
- R8: A start request while active, or a stop request while inactive, has no effect: `busy` stays low, no write is issued, and the pins do not change.
- R9: Start and stop requests that arrive while `busy` is high are ignored. The running sequence completes unchanged.
- R10: If start and stop are both raised in the same idle cycle, the block acts on the one that fits its state. When inactive it starts up; when active it shuts down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startReq | input | 1 | Request to bring the panel up |
| stopReq | input | 1 | Request to shut the panel down |
| vsyncIn | input | 1 | Vertical sync, rising edge marks a frame |
| wrReady | input | 1 | Serial register writer can accept a write |
| wrValid | output | 1 | A register write is offered |
| wrAddr | output | 8 | Panel register number |
| wrData | output | 16 | Value for the panel register |
| panelRstN | output | 1 | Panel reset line, low = reset asserted |
| powerEn | output | 1 | Panel power enable |
| busy | output | 1 | A sequence is running |
| done | output | 1 | One-cycle pulse at sequence end |
| active | output | 1 | Panel is powered and initialised |

## Verification
Two idle-state decisions can meet in one cycle: accepting a start-up and accepting a shut-down. The bench raises both requests on the same edge, once while inactive and once while active. In the inactive case it judges the outcome by whether `panelRstN` falls on the next cycle. In the active case it judges by whether the first write seen by the scoreboard is the shut-down write to register 0B. Requests injected in the middle of a running sequence must leave the scoreboard order and the final `active` value untouched.

// File: rtl/panel_seq_pkg.sv
`timescale 1ns/1ps
package panel_seq_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 16;
  localparam int PTR_W  = 5;
  localparam logic [PTR_W-1:0] UP_BASE   = 5'd0;
  localparam logic [PTR_W-1:0] DOWN_BASE = 5'd21;

  typedef enum logic [1:0] {
    OP_WRITE    = 2'd0,
    OP_WAIT_MS  = 2'd1,
    OP_WAIT_FRM = 2'd2,
    OP_END      = 2'd3
  } seqOp_e;

  typedef struct packed {
    seqOp_e            op;
    logic [ADDR_W-1:0] regAddr;
    logic [DATA_W-1:0] val;
  } seqEntry_t;

  // strobes from control to datapath
  typedef struct packed {
    logic              msLoad;
    logic              frmLoad;
    logic              ptrLoad;
    logic              ptrInc;
    logic [DATA_W-1:0] amount;
    logic [PTR_W-1:0]  ptrVal;
  } dpCmd_t;

  function automatic seqEntry_t mkEntry(seqOp_e op, logic [ADDR_W-1:0] a, logic [DATA_W-1:0] v);
    seqEntry_t e;
    e.op = op;
    e.regAddr = a;
    e.val = v;
    return e;
  endfunction

  // constant script: bring-up part from UP_BASE, shut-down part from DOWN_BASE
  function automatic seqEntry_t scriptAt(logic [PTR_W-1:0] idx);
    case (idx)
      5'd0:  return mkEntry(OP_WRITE,    8'h07, 16'h0000);
      5'd1:  return mkEntry(OP_WAIT_MS,  8'h00, 16'd10);
      5'd2:  return mkEntry(OP_WRITE,    8'h12, 16'h1618);
      5'd3:  return mkEntry(OP_WRITE,    8'h11, 16'h2227);
      5'd4:  return mkEntry(OP_WRITE,    8'h13, 16'h61D1);
      5'd5:  return mkEntry(OP_WRITE,    8'h10, 16'h550C);
      5'd6:  return mkEntry(OP_WAIT_FRM, 8'h00, 16'd5);
      5'd7:  return mkEntry(OP_WRITE,    8'h12, 16'h0C58);
      5'd8:  return mkEntry(OP_WRITE,    8'h01, 16'h231D);
      5'd9:  return mkEntry(OP_WRITE,    8'h02, 16'h0300);
      5'd10: return mkEntry(OP_WRITE,    8'h03, 16'hD040);
      5'd11: return mkEntry(OP_WRITE,    8'h07, 16'h0001);
      5'd12: return mkEntry(OP_WAIT_FRM, 8'h00, 16'd1);
      5'd13: return mkEntry(OP_WRITE,    8'h07, 16'h0101);
      5'd14: return mkEntry(OP_WAIT_FRM, 8'h00, 16'd2);
      5'd15: return mkEntry(OP_WRITE,    8'h76, 16'h2213);
      5'd16: return mkEntry(OP_WRITE,    8'h1C, 16'h6650);
      5'd17: return mkEntry(OP_WRITE,    8'h0B, 16'h33E1);
      5'd18: return mkEntry(OP_WRITE,    8'h76, 16'h0000);
      5'd19: return mkEntry(OP_WRITE,    8'h07, 16'h0103);
      5'd20: return mkEntry(OP_END,      8'h00, 16'h0000);
      5'd21: return mkEntry(OP_WRITE,    8'h0B, 16'h30E1);
      5'd22: return mkEntry(OP_WRITE,    8'h07, 16'h0102);
      5'd23: return mkEntry(OP_WAIT_FRM, 8'h00, 16'd2);
      5'd24: return mkEntry(OP_WRITE,    8'h07, 16'h0000);
      5'd25: return mkEntry(OP_WRITE,    8'h12, 16'h0000);
      5'd26: return mkEntry(OP_WRITE,    8'h10, 16'h0100);
      default: return mkEntry(OP_END,    8'h00, 16'h0000);
    endcase
  endfunction
endpackage

// File: rtl/panel_seq_dp.sv
`timescale 1ns/1ps
module panel_seq_dp
  import panel_seq_pkg::*;
#(
  parameter int CLK_PER_MS = 24000,
  parameter int FRAME_PAD  = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      vsyncIn,
  input  dpCmd_t    cmd,
  output seqEntry_t entry,
  output logic      waitDone
);
  localparam int PRE_W = (CLK_PER_MS > 1) ? $clog2(CLK_PER_MS) : 1;
  localparam int CNT_W = DATA_W + 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CLK_PER_MS - 1);

  logic [PTR_W-1:0] ptr;
  logic [PRE_W-1:0] pre;
  logic [CNT_W-1:0] remain;
  logic [CNT_W-1:0] loadVal;
  logic             running;
  logic             frmMode;
  logic             vsyncQ;
  logic             vsyncEdge;
  logic             tick;

  assign entry     = scriptAt(ptr);
  assign vsyncEdge = vsyncIn & ~vsyncQ;

  always_comb begin
    loadVal = CNT_W'(cmd.amount);
    if (cmd.frmLoad) loadVal = CNT_W'(cmd.amount) + CNT_W'(FRAME_PAD);
    tick = running && (frmMode ? vsyncEdge : (pre == PRE_LAST));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr      <= '0;
      pre      <= '0;
      remain   <= '0;
      running  <= 1'b0;
      frmMode  <= 1'b0;
      vsyncQ   <= 1'b0;
      waitDone <= 1'b0;
    end else begin
      vsyncQ   <= vsyncIn;
      waitDone <= 1'b0;
      if (cmd.ptrLoad)     ptr <= cmd.ptrVal;
      else if (cmd.ptrInc) ptr <= ptr + PTR_W'(1);
      if (cmd.msLoad || cmd.frmLoad) begin
        remain   <= loadVal;
        pre      <= '0;
        frmMode  <= cmd.frmLoad;
        running  <= (loadVal != '0);
        waitDone <= (loadVal == '0);
      end else if (running) begin
        if (!frmMode) pre <= (pre == PRE_LAST) ? '0 : pre + PRE_W'(1);
        if (tick) begin
          remain <= remain - CNT_W'(1);
          if (remain == CNT_W'(1)) begin
            running  <= 1'b0;
            waitDone <= 1'b1;
          end
        end
      end
    end
  end

  // frame count only moves on a sync edge
  p_frame_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (running && frmMode && !vsyncEdge && !cmd.msLoad && !cmd.frmLoad) |=> $stable(remain));
  p_wait_single_r4: assert property (@(posedge clk) disable iff (!rstN)
    waitDone |=> !waitDone);
endmodule

// File: rtl/panel_seq_ctrl.sv
`timescale 1ns/1ps
module panel_seq_ctrl
  import panel_seq_pkg::*;
#(
  parameter int RST_HOLD_MS = 1,
  parameter int PWR_HOLD_MS = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic              stopReq,
  input  seqEntry_t         entry,
  input  logic              waitDone,
  input  logic              wrReady,
  output dpCmd_t            cmd,
  output logic              wrValid,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [DATA_W-1:0] wrData,
  output logic              panelRstN,
  output logic              powerEn,
  output logic              busy,
  output logic              done,
  output logic              active
);
  typedef enum logic [2:0] {
    S_IDLE, S_RST_HOLD, S_RST_SETTLE, S_PWR_HOLD, S_RUN, S_WAIT
  } ctlState_e;

  ctlState_e state, nxt;
  logic      goingUp;

  assign busy   = (state != S_IDLE);
  assign wrAddr = entry.regAddr;
  assign wrData = entry.val;

  always_comb begin
    nxt     = state;
    cmd     = '0;
    wrValid = 1'b0;
    case (state)
      S_IDLE: begin
        if (startReq && !active) begin
          nxt = S_RST_HOLD;
          cmd.msLoad = 1'b1;
          cmd.amount = DATA_W'(RST_HOLD_MS);
        end else if (stopReq && active) begin
          nxt = S_RUN;
          cmd.ptrLoad = 1'b1;
          cmd.ptrVal  = DOWN_BASE;
        end
      end
      S_RST_HOLD: if (waitDone) begin
        nxt = S_RST_SETTLE;
        cmd.msLoad = 1'b1;
        cmd.amount = DATA_W'(RST_HOLD_MS);
      end
      S_RST_SETTLE: if (waitDone) begin
        nxt = S_PWR_HOLD;
        cmd.msLoad = 1'b1;
        cmd.amount = DATA_W'(PWR_HOLD_MS);
      end
      S_PWR_HOLD: if (waitDone) begin
        if (goingUp) begin
          nxt = S_RUN;
          cmd.ptrLoad = 1'b1;
          cmd.ptrVal  = UP_BASE;
        end else begin
          nxt = S_IDLE;
        end
      end
      S_RUN: begin
        case (entry.op)
          OP_WRITE: begin
            wrValid    = 1'b1;
            cmd.ptrInc = wrReady;
          end
          OP_WAIT_MS: begin
            cmd.msLoad = 1'b1;
            cmd.amount = entry.val;
            cmd.ptrInc = 1'b1;
            nxt = S_WAIT;
          end
          OP_WAIT_FRM: begin
            cmd.frmLoad = 1'b1;
            cmd.amount  = entry.val;
            cmd.ptrInc  = 1'b1;
            nxt = S_WAIT;
          end
          default: begin
            if (goingUp) begin
              nxt = S_IDLE;
            end else begin
              nxt = S_PWR_HOLD;
              cmd.msLoad = 1'b1;
              cmd.amount = DATA_W'(PWR_HOLD_MS);
            end
          end
        endcase
      end
      S_WAIT: if (waitDone) nxt = S_RUN;
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= S_IDLE;
      goingUp   <= 1'b0;
      panelRstN <= 1'b1;
      powerEn   <= 1'b0;
      active    <= 1'b0;
      done      <= 1'b0;
    end else begin
      state <= nxt;
      done  <= (state != S_IDLE) && (nxt == S_IDLE);
      case (state)
        S_IDLE: begin
          if (startReq && !active) begin
            goingUp   <= 1'b1;
            panelRstN <= 1'b0;
          end else if (stopReq && active) begin
            goingUp <= 1'b0;
          end
        end
        S_RST_HOLD:   if (waitDone) panelRstN <= 1'b1;
        S_RST_SETTLE: if (waitDone) powerEn <= 1'b1;
        S_PWR_HOLD:   if (waitDone && !goingUp) active <= 1'b0;
        S_RUN: if (entry.op == OP_END) begin
          if (goingUp) active  <= 1'b1;
          else         powerEn <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  p_wr_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && !wrReady) |=> (wrValid && $stable(wrAddr) && $stable(wrData)));
  p_wr_powered_r2: assert property (@(posedge clk) disable iff (!rstN)
    wrValid |-> (powerEn && panelRstN));
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  p_done_state_r6: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && (active == powerEn)));
  p_start_ignored_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && active && startReq && !stopReq) |=> !busy);
  p_stop_ignored_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !active && stopReq && !startReq) |=> !busy);
  p_dir_locked_r9: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(goingUp));
endmodule

// File: rtl/panel_seq.sv
`timescale 1ns/1ps
module panel_seq
  import panel_seq_pkg::*;
#(
  parameter int CLK_PER_MS  = 24000,
  parameter int RST_HOLD_MS = 1,
  parameter int PWR_HOLD_MS = 10,
  parameter int FRAME_PAD   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic              stopReq,
  input  logic              vsyncIn,
  input  logic              wrReady,
  output logic              wrValid,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [DATA_W-1:0] wrData,
  output logic              panelRstN,
  output logic              powerEn,
  output logic              busy,
  output logic              done,
  output logic              active
);
  dpCmd_t    cmd;
  seqEntry_t entry;
  logic      waitDone;

  panel_seq_ctrl #(
    .RST_HOLD_MS(RST_HOLD_MS),
    .PWR_HOLD_MS(PWR_HOLD_MS)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .stopReq(stopReq),
    .entry(entry), .waitDone(waitDone), .wrReady(wrReady), .cmd(cmd),
    .wrValid(wrValid), .wrAddr(wrAddr), .wrData(wrData),
    .panelRstN(panelRstN), .powerEn(powerEn), .busy(busy),
    .done(done), .active(active)
  );

  panel_seq_dp #(
    .CLK_PER_MS(CLK_PER_MS),
    .FRAME_PAD(FRAME_PAD)
  ) u_dp (
    .clk(clk), .rstN(rstN), .vsyncIn(vsyncIn), .cmd(cmd),
    .entry(entry), .waitDone(waitDone)
  );
endmodule

// File: tb/panel_seq_tb.sv
`timescale 1ns/1ps
module panel_seq_tb;
  localparam int CPM = 20;

  logic clk = 1'b0, rstN = 1'b0, startReq = 1'b0, stopReq = 1'b0;
  logic vsync = 1'b0, wrReady = 1'b1;
  logic wrValid, panelRstN, powerEn, busy, done, active;
  logic [7:0]  wrAddr;
  logic [15:0] wrData;

  panel_seq #(.CLK_PER_MS(CPM)) u_dut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .stopReq(stopReq),
    .vsyncIn(vsync), .wrReady(wrReady), .wrValid(wrValid), .wrAddr(wrAddr),
    .wrData(wrData), .panelRstN(panelRstN), .powerEn(powerEn), .busy(busy),
    .done(done), .active(active)
  );

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0, edgeCnt = 0, accN = 0, rdyWait = 0;
  int cycAt[64];
  int edgeAt[64];
  logic [23:0] expQ[$];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic pushW(input logic [7:0] a, input logic [15:0] d);
    expQ.push_back({a, d});
  endtask

  task automatic pushUp;
    pushW(8'h07,16'h0000); pushW(8'h12,16'h1618); pushW(8'h11,16'h2227);
    pushW(8'h13,16'h61D1); pushW(8'h10,16'h550C); pushW(8'h12,16'h0C58);
    pushW(8'h01,16'h231D); pushW(8'h02,16'h0300); pushW(8'h03,16'hD040);
    pushW(8'h07,16'h0001); pushW(8'h07,16'h0101); pushW(8'h76,16'h2213);
    pushW(8'h1C,16'h6650); pushW(8'h0B,16'h33E1); pushW(8'h76,16'h0000);
    pushW(8'h07,16'h0103);
  endtask

  task automatic pushDown;
    pushW(8'h0B,16'h30E1); pushW(8'h07,16'h0102); pushW(8'h07,16'h0000);
    pushW(8'h12,16'h0000); pushW(8'h10,16'h0100);
  endtask

  task automatic waitForDone(output bit seen);
    seen = 1'b0;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (done) begin seen = 1'b1; break; end
    end
  endtask

  // vsync source
  initial begin
    forever begin
      repeat (90) @(negedge clk);
      vsync = 1'b1; edgeCnt++;
      repeat (10) @(negedge clk);
      vsync = 1'b0;
    end
  end

  // serial writer model and scoreboard monitor
  always @(posedge clk) begin
    cyc++;
    if (wrValid && wrReady) begin
      logic [23:0] e;
      cycAt[accN % 64]  = cyc;
      edgeAt[accN % 64] = edgeCnt;
      accN++;
      if (expQ.size() == 0) begin
        check(1'b0, "R3 unexpected write", int'({wrAddr, wrData}), 0);
      end else begin
        e = expQ.pop_front();
        check({wrAddr, wrData} == e, "R3 write order", int'({wrAddr, wrData}), int'(e));
      end
      wrReady <= 1'b0;
      rdyWait = 8;
    end else if (rdyWait > 0) begin
      rdyWait--;
      if (rdyWait == 0) wrReady <= 1'b1;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    report();
  end

  initial begin
    int n, m, pwrCyc, offCyc, d;
    bit seen, sawBusy;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 idle state
    check({busy,done,active,powerEn,panelRstN,wrValid} == 6'b000010, "R1 reset state",
          int'({busy,done,active,powerEn,panelRstN,wrValid}), 6'b000010);

    // R8 stop while inactive
    stopReq = 1'b1; @(negedge clk); stopReq = 1'b0;
    sawBusy = 1'b0;
    for (int i = 0; i < 20; i++) begin @(negedge clk); if (busy || !panelRstN || powerEn) sawBusy = 1'b1; end
    check(!sawBusy && accN == 0, "R8 stop while inactive", int'(sawBusy), 0);

    // start-up
    pushUp();
    startReq = 1'b1; @(negedge clk); startReq = 1'b0;
    check(!panelRstN && !powerEn && busy, "R2 reset asserted first", int'({panelRstN,powerEn}), 0);
    n = 1;
    while (!panelRstN && n < 10000) begin @(negedge clk); if (!panelRstN) n++; end
    check(n >= CPM && n <= CPM + 3, "R2 reset low time", n, CPM + 1);
    check(!powerEn, "R2 power after reset release", int'(powerEn), 0);
    m = 1;
    while (!powerEn && m < 10000) begin @(negedge clk); if (!powerEn) m++; end
    check(m >= CPM && m <= CPM + 3, "R2 reset release hold", m, CPM + 1);
    pwrCyc = cyc;
    // R9 stop during start-up
    @(negedge clk); stopReq = 1'b1; @(negedge clk); stopReq = 1'b0;
    waitForDone(seen);
    check(seen, "R6 start-up done seen", int'(seen), 1);
    check(active && !busy && powerEn, "R6 done state", int'({active,busy,powerEn}), 3'b101);
    @(negedge clk);
    check(!done, "R6 done one cycle", int'(done), 0);
    check(accN == 16 && expQ.size() == 0, "R9 start-up unaffected by stop", accN, 16);
    d = cycAt[0] - pwrCyc;
    check(d >= 10*CPM && d <= 10*CPM + 4, "R2 power to first write", d, 10*CPM + 2);
    d = cycAt[1] - cycAt[0];
    check(d >= 10*CPM && d <= 10*CPM + 6, "R4 ms wait", d, 10*CPM + 3);
    d = edgeAt[5] - edgeAt[4];
    check(d >= 7 && d <= 8, "R5 five-frame wait", d, 7);
    d = edgeAt[10] - edgeAt[9];
    check(d == 3, "R5 one-frame wait", d, 3);
    d = edgeAt[11] - edgeAt[10];
    check(d == 4, "R5 two-frame wait", d, 4);

    // R8 start while active
    startReq = 1'b1; @(negedge clk); startReq = 1'b0;
    sawBusy = 1'b0;
    for (int i = 0; i < 30; i++) begin @(negedge clk); if (busy || !panelRstN) sawBusy = 1'b1; end
    check(!sawBusy && accN == 16 && active, "R8 start while active", int'(sawBusy), 0);

    // R10 both requests while active: shut-down, aligned away from sync edges
    @(posedge vsync);
    repeat (20) @(negedge clk);
    pushDown();
    startReq = 1'b1; stopReq = 1'b1; @(negedge clk); startReq = 1'b0; stopReq = 1'b0;
    check(busy && panelRstN, "R10 both while active shuts down", int'({busy,panelRstN}), 2'b11);
    repeat (30) @(negedge clk);
    startReq = 1'b1; @(negedge clk); startReq = 1'b0;   // R9 start during shut-down
    n = 0;
    while (powerEn && n < 20000) begin @(negedge clk); n++; end
    offCyc = cyc;
    d = offCyc - cycAt[20];
    check(accN == 21 && d >= 1 && d <= 3, "R7 power off after last write", d, 1);
    waitForDone(seen);
    d = cyc - offCyc;
    check(seen && d >= 10*CPM && d <= 10*CPM + 4, "R7 power hold before done", d, 10*CPM + 1);
    check(!active && panelRstN && !powerEn, "R7 final state", int'({active,panelRstN,powerEn}), 3'b010);
    check(expQ.size() == 0, "R9 shut-down unaffected by start", expQ.size(), 0);
    d = edgeAt[18] - edgeAt[17];
    check(d == 4, "R5 shut-down frame wait", d, 4);

    // R10 both requests while inactive: start-up
    repeat (5) @(negedge clk);
    pushUp();
    startReq = 1'b1; stopReq = 1'b1; @(negedge clk); startReq = 1'b0; stopReq = 1'b0;
    check(!panelRstN && busy, "R10 both while inactive starts up", int'(panelRstN), 0);
    waitForDone(seen);
    check(seen && active && accN == 37 && expQ.size() == 0, "R10 second start-up completes", accN, 37);
    repeat (5) @(negedge clk);
    report();
  end
endmodule